// File: doc/BRIEF.md
# Transceiver PMA Reset Sequencer

This block restarts the internal analog-side controller of a serial transceiver channel by acting as a master on a memory-mapped register bus with a wait-request handshake and pipelined read responses. A one-cycle start pulse launches a fixed chain of byte-wide register writes that arms the controller's reset. The sequencer then reads a status register over and over until a completion flag comes back set, and reads a result register to learn whether the reset worked.

A reset of that controller wipes the channel's rate and serializer settings. When the caller asks for it, a successful reset is therefore followed by a read-modify-write that sets one bit in a configuration register, which makes the transceiver reload its stored settings. A caller-supplied poll budget bounds the wait for completion. The caller sees a busy level, a one-cycle done pulse, and error and timeout flags that remain valid until the next start.

Top module: `pmaResetSeq`

## Requirements
- R1: After an accepted start, the first four bus transfers are writes in this exact order: address 0x200 data 0x00, 0x201 data 0x00, 0x202 data 0x00, 0x203 data 0x81. The data sits in bits [7:0] and all bits above are zero.
- R2: After the fourth write, the block reads address 0x207 repeatedly. It stops at the first read whose bit 7 is 1 and does not rely on that bit staying set, because the register clears it when read.
- R3: Once completion is seen, the block reads address 0x204 once. If bit 0 is 1, error is 1 at done. If bit 0 is 0, the reset counts as successful and error is 0.
- R4: If reloadEn was high at the accepted start and R3 found success, the block reads address 0x91 and writes it back with bit 0 set and every other bit unchanged. It does neither transfer on failure or when reloadEn was low.
- R5: While read or write is high and waitrequest is high, the address, the write data and the request lines stay unchanged. A transfer is accepted on a cycle with waitrequest low. Read data is taken only on a cycle with readdatavalid high at least one cycle after acceptance; readdata is ignored in all other cycles.
- R6: At most max(pollLimit, 1) reads of 0x207 are made. If none of them returns bit 7 set, timeout and error are both 1 at done, and address 0x204 is not read.
- R7: start is accepted only when busy is 0. busy is 1 from the cycle after the accepted start through the done cycle, and a start while busy starts nothing new.
- R8: done is high for exactly one cycle when a sequence ends, on both success and failure. busy is 0 in the following cycle. error and timeout are valid in the done cycle, stay unchanged until the next accepted start, and are cleared by that start.
- R9: A synchronous active-high rst, even in the middle of a sequence, drops read and write in the next cycle and leaves busy, done, error and timeout at 0.
- R10: read and write are never high in the same cycle, and no new request is made while a read response is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, taken in idle only |
| reloadEn | input | 1 | Request a settings reload after a successful reset (sampled at start) |
| pollLimit | input | POLL_W | Maximum number of completion-status reads |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| error | output | 1 | Sequence failed (bad result or timeout) |
| timeout | output | 1 | Completion not seen within the poll budget |
| avAddress | output | ADDR_W | Bus address |
| avWrite | output | 1 | Write request |
| avWriteData | output | DATA_W | Write data |
| avRead | output | 1 | Read request |
| avReadData | input | DATA_W | Read response data |
| avReadDataValid | input | 1 | Read response valid |
| avWaitRequest | input | 1 | Slave stall; request must be held |

## Verification
Assertions check, on every cycle, the handshake rules of the bus: a stalled request keeps its address, data and direction; read and write never overlap; and nothing new is issued while a read response is pending. They also check that done lasts one cycle and is followed by idle, that busy only rises after a start, and that timeout never appears without error. The order and contents of the write chain, the correct number of status polls against a self-clearing completion flag, the choice between reading the result register or timing out, and the preserved bits of the reload write can only be shown by the bench scenarios. Those scenarios vary stall length, read latency, completion delay, result bit and poll budget against a register-model slave.

// File: rtl/pmaRstPkg.sv
package pmaRstPkg;

  // which register a bus transfer addresses
  typedef enum logic [1:0] {
    TGT_SEQ    = 2'd0,
    TGT_POLL   = 2'd1,
    TGT_RESULT = 2'd2,
    TGT_RELOAD = 2'd3
  } target_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEQ,
    ST_POLL,
    ST_RESULT,
    ST_RLREAD,
    ST_RLWRITE,
    ST_END
  } state_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic    launch;
    logic    isRead;
    target_e target;
    logic [1:0] seqIdx;
    logic    clrFlags;
    logic    setErr;
    logic    setTimeout;
    logic    clrPoll;
    logic    incPoll;
  } strobes_t;

endpackage

// File: rtl/pmaRstDatapath.sv
module pmaRstDatapath
  import pmaRstPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int POLL_W = 16,
  parameter logic [ADDR_W-1:0] SEQ_BASE    = 'h200,
  parameter logic [ADDR_W-1:0] POLL_ADDR   = 'h207,
  parameter logic [ADDR_W-1:0] RESULT_ADDR = 'h204,
  parameter logic [ADDR_W-1:0] RELOAD_ADDR = 'h091,
  parameter logic [7:0] ARM_CODE = 8'h81,
  parameter int DONE_BIT   = 7,
  parameter int FAIL_BIT   = 0,
  parameter int RELOAD_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  strobes_t          stb,
  input  logic [POLL_W-1:0] pollLimit,
  output logic [ADDR_W-1:0] avAddress,
  output logic              avWrite,
  output logic [DATA_W-1:0] avWriteData,
  output logic              avRead,
  input  logic [DATA_W-1:0] avReadData,
  input  logic              avReadDataValid,
  input  logic              avWaitRequest,
  output logic              xferDone,
  output logic              doneBit,
  output logic              failBit,
  output logic              pollExpired,
  output logic              error,
  output logic              timeout
);

  localparam logic [DATA_W-1:0] RELOAD_MASK = DATA_W'(1) << RELOAD_BIT;
  localparam logic [POLL_W-1:0] POLL_MAX    = '1;

  logic [DATA_W-1:0] rdData;
  logic              rdPending;
  logic [POLL_W-1:0] pollCnt;
  logic [ADDR_W-1:0] nextAddr;
  logic [DATA_W-1:0] nextData;

  // byte written at each step of the arming chain
  function automatic logic [DATA_W-1:0] seqByte(input logic [1:0] idx);
    return (idx == 2'd3) ? DATA_W'(ARM_CODE) : '0;
  endfunction

  always_comb begin
    nextAddr = POLL_ADDR;
    nextData = '0;
    case (stb.target)
      TGT_SEQ: begin
        nextAddr = SEQ_BASE + ADDR_W'(stb.seqIdx);
        nextData = seqByte(stb.seqIdx);
      end
      TGT_POLL:   nextAddr = POLL_ADDR;
      TGT_RESULT: nextAddr = RESULT_ADDR;
      TGT_RELOAD: begin
        nextAddr = RELOAD_ADDR;
        nextData = rdData | RELOAD_MASK;
      end
      default: ;
    endcase
  end

  // bus request engine: one transfer outstanding at a time
  always_ff @(posedge clk) begin
    if (rst) begin
      avAddress   <= '0;
      avWriteData <= '0;
      avWrite     <= 1'b0;
      avRead      <= 1'b0;
      rdPending   <= 1'b0;
      rdData      <= '0;
      xferDone    <= 1'b0;
    end else begin
      xferDone <= 1'b0;
      if (stb.launch) begin
        avAddress   <= nextAddr;
        avWriteData <= nextData;
        avWrite     <= !stb.isRead;
        avRead      <= stb.isRead;
      end else if ((avWrite || avRead) && !avWaitRequest) begin
        avWrite   <= 1'b0;
        avRead    <= 1'b0;
        rdPending <= avRead;
        if (avWrite) xferDone <= 1'b1;
      end
      if (rdPending && avReadDataValid) begin
        rdData    <= avReadData;
        rdPending <= 1'b0;
        xferDone  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pollCnt <= '0;
      error   <= 1'b0;
      timeout <= 1'b0;
    end else begin
      if (stb.clrPoll) pollCnt <= '0;
      else if (stb.incPoll && pollCnt != POLL_MAX) pollCnt <= pollCnt + 1'b1;
      if (stb.clrFlags) begin
        error   <= 1'b0;
        timeout <= 1'b0;
      end
      if (stb.setErr)     error   <= 1'b1;
      if (stb.setTimeout) timeout <= 1'b1;
    end
  end

  assign doneBit     = rdData[DONE_BIT];
  assign failBit     = rdData[FAIL_BIT];
  assign pollExpired = (pollCnt >= pollLimit);

  // R5: a stalled request holds address, data and direction
  a_r5_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    (avWrite || avRead) && avWaitRequest |=>
      $stable(avAddress) && $stable(avWriteData) && $stable(avWrite) && $stable(avRead));

  // R10: never read and write together
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(avRead && avWrite));

  // R10: no request while a read response is pending
  a_r10_single_outstanding: assert property (@(posedge clk) disable iff (rst)
    rdPending |-> !avRead && !avWrite);

  // R6: timeout always comes with error
  a_r6_timeout_err: assert property (@(posedge clk) disable iff (rst)
    timeout |-> error);

endmodule

// File: rtl/pmaRstControl.sv
module pmaRstControl
  import pmaRstPkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     start,
  input  logic     reloadEn,
  input  logic     xferDone,
  input  logic     doneBit,
  input  logic     failBit,
  input  logic     pollExpired,
  output strobes_t stb,
  output logic     busy,
  output logic     done
);

  state_e     state, stateNext;
  logic [1:0] seqIdx;
  logic       reloadArmed;

  always_comb begin
    stb       = '0;
    stateNext = state;
    case (state)
      ST_IDLE: if (start) begin
        stb.clrFlags = 1'b1;
        stb.clrPoll  = 1'b1;
        stb.launch   = 1'b1;
        stb.target   = TGT_SEQ;
        stb.seqIdx   = 2'd0;
        stateNext    = ST_SEQ;
      end
      ST_SEQ: if (xferDone) begin
        stb.launch = 1'b1;
        if (seqIdx == 2'd3) begin
          stb.isRead  = 1'b1;
          stb.target  = TGT_POLL;
          stb.incPoll = 1'b1;
          stateNext   = ST_POLL;
        end else begin
          stb.target = TGT_SEQ;
          stb.seqIdx = seqIdx + 2'd1;
        end
      end
      ST_POLL: if (xferDone) begin
        if (doneBit) begin
          stb.launch = 1'b1;
          stb.isRead = 1'b1;
          stb.target = TGT_RESULT;
          stateNext  = ST_RESULT;
        end else if (pollExpired) begin
          stb.setErr     = 1'b1;
          stb.setTimeout = 1'b1;
          stateNext      = ST_END;
        end else begin
          stb.launch  = 1'b1;
          stb.isRead  = 1'b1;
          stb.target  = TGT_POLL;
          stb.incPoll = 1'b1;
        end
      end
      ST_RESULT: if (xferDone) begin
        if (failBit) begin
          stb.setErr = 1'b1;
          stateNext  = ST_END;
        end else if (reloadArmed) begin
          stb.launch = 1'b1;
          stb.isRead = 1'b1;
          stb.target = TGT_RELOAD;
          stateNext  = ST_RLREAD;
        end else begin
          stateNext = ST_END;
        end
      end
      ST_RLREAD: if (xferDone) begin
        stb.launch = 1'b1;
        stb.target = TGT_RELOAD;
        stateNext  = ST_RLWRITE;
      end
      ST_RLWRITE: if (xferDone) stateNext = ST_END;
      ST_END:     stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      seqIdx      <= 2'd0;
      reloadArmed <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE && start) begin
        seqIdx      <= 2'd0;
        reloadArmed <= reloadEn;
      end else if (state == ST_SEQ && xferDone) begin
        seqIdx <= seqIdx + 2'd1;
      end
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_END);

  // R8: done lasts one cycle and the block is idle afterwards
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done && !busy);

  // R7: busy only rises after a start
  a_r7_busy_needs_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

endmodule

// File: rtl/pmaResetSeq.sv
module pmaResetSeq
  import pmaRstPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int POLL_W = 16,
  parameter logic [ADDR_W-1:0] SEQ_BASE    = 'h200,
  parameter logic [ADDR_W-1:0] POLL_ADDR   = 'h207,
  parameter logic [ADDR_W-1:0] RESULT_ADDR = 'h204,
  parameter logic [ADDR_W-1:0] RELOAD_ADDR = 'h091,
  parameter logic [7:0] ARM_CODE = 8'h81,
  parameter int DONE_BIT   = 7,
  parameter int FAIL_BIT   = 0,
  parameter int RELOAD_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              reloadEn,
  input  logic [POLL_W-1:0] pollLimit,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              timeout,
  output logic [ADDR_W-1:0] avAddress,
  output logic              avWrite,
  output logic [DATA_W-1:0] avWriteData,
  output logic              avRead,
  input  logic [DATA_W-1:0] avReadData,
  input  logic              avReadDataValid,
  input  logic              avWaitRequest
);

  strobes_t stb;
  logic xferDone, doneBit, failBit, pollExpired;

  pmaRstControl uCtrl (
    .clk(clk), .rst(rst), .start(start), .reloadEn(reloadEn),
    .xferDone(xferDone), .doneBit(doneBit), .failBit(failBit),
    .pollExpired(pollExpired), .stb(stb), .busy(busy), .done(done)
  );

  pmaRstDatapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .POLL_W(POLL_W),
    .SEQ_BASE(SEQ_BASE), .POLL_ADDR(POLL_ADDR), .RESULT_ADDR(RESULT_ADDR),
    .RELOAD_ADDR(RELOAD_ADDR), .ARM_CODE(ARM_CODE), .DONE_BIT(DONE_BIT),
    .FAIL_BIT(FAIL_BIT), .RELOAD_BIT(RELOAD_BIT)
  ) uData (
    .clk(clk), .rst(rst), .stb(stb), .pollLimit(pollLimit),
    .avAddress(avAddress), .avWrite(avWrite), .avWriteData(avWriteData),
    .avRead(avRead), .avReadData(avReadData), .avReadDataValid(avReadDataValid),
    .avWaitRequest(avWaitRequest), .xferDone(xferDone), .doneBit(doneBit),
    .failBit(failBit), .pollExpired(pollExpired), .error(error), .timeout(timeout)
  );

endmodule

// File: tb/pmaResetSeq_test.sv
`timescale 1ns/1ps
module pmaResetSeq_test;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst, start, reloadEn;
  logic [15:0] pollLimit;
  logic        busy, done, error, timeout;
  logic [11:0] avAddress;
  logic        avWrite, avRead, avReadDataValid, avWaitRequest;
  logic [31:0] avWriteData, avReadData;

  pmaResetSeq uut (
    .clk(clk), .rst(rst), .start(start), .reloadEn(reloadEn), .pollLimit(pollLimit),
    .busy(busy), .done(done), .error(error), .timeout(timeout),
    .avAddress(avAddress), .avWrite(avWrite), .avWriteData(avWriteData),
    .avRead(avRead), .avReadData(avReadData), .avReadDataValid(avReadDataValid),
    .avWaitRequest(avWaitRequest)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- register-model slave ----------------
  localparam logic [31:0] REG91_INIT = 32'h0000_00A4;
  logic [3:0]  waitCfg = 4'd0;
  logic [3:0]  rdLat = 4'd1;
  logic [7:0]  compDelay = 8'd0;
  logic        resBit = 1'b0;
  logic        slvClear = 1'b0;
  logic [31:0] reg91;
  logic        armed;
  int          pollsSeen, waitCnt, respCnt, logN, holdViol;
  logic [31:0] respData;
  logic        logW [64];
  logic [11:0] logA [64];
  logic [31:0] logD [64];
  logic        holdPending;
  logic [11:0] holdA;
  logic [31:0] holdD;
  logic [1:0]  holdRW;

  assign avWaitRequest = (avRead || avWrite) && (waitCnt < int'(waitCfg));
  assign avReadData    = avReadDataValid ? respData : 32'hFFFF_FFFF;

  always @(posedge clk) begin
    avReadDataValid <= 1'b0;
    if (slvClear) begin
      logN <= 0; reg91 <= REG91_INIT; armed <= 1'b0; pollsSeen <= 0;
      waitCnt <= 0; respCnt <= 0;
    end else begin
      if (respCnt > 0) begin
        respCnt <= respCnt - 1;
        if (respCnt == 1) avReadDataValid <= 1'b1;
      end
      if (avRead || avWrite) begin
        if (waitCnt < int'(waitCfg)) waitCnt <= waitCnt + 1;
        else begin
          waitCnt <= 0;
          if (logN < 64) begin
            logW[logN] <= avWrite; logA[logN] <= avAddress; logD[logN] <= avWriteData;
          end
          logN <= logN + 1;
          if (avWrite) begin
            if (avAddress == 12'h203 && avWriteData[7:0] == 8'h81) begin
              armed <= 1'b1; pollsSeen <= 0;
            end
            if (avAddress == 12'h091) reg91 <= avWriteData;
          end else begin
            respCnt <= int'(rdLat);
            case (avAddress)
              12'h207: begin
                if (armed && pollsSeen >= int'(compDelay)) begin
                  respData <= 32'h80; armed <= 1'b0;
                end else respData <= 32'h0;
                pollsSeen <= pollsSeen + 1;
              end
              12'h204: respData <= {31'b0, resBit};
              12'h091: respData <= reg91;
              default: respData <= 32'h0;
            endcase
          end
        end
      end
    end
  end

  // stall-hold monitor (R5)
  initial holdViol = 0;
  always @(posedge clk) begin
    if (holdPending && (avAddress !== holdA || avWriteData !== holdD ||
                        {avRead, avWrite} !== holdRW))
      holdViol <= holdViol + 1;
    holdPending <= (avRead || avWrite) && avWaitRequest && !rst;
    holdA <= avAddress; holdD <= avWriteData; holdRW <= {avRead, avWrite};
  end

  // ---------------- vector table ----------------
  typedef struct packed {
    logic [3:0]  wt;
    logic [3:0]  lat;
    logic [7:0]  dly;
    logic [15:0] lim;
    logic        res;
    logic        rl;
    logic        expErr;
    logic        expTo;
    logic [7:0]  expPolls;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 4'd1, 8'd0, 16'd8, 1'b0, 1'b1, 1'b0, 1'b0, 8'd1},
    '{4'd2, 4'd3, 8'd3, 16'd8, 1'b0, 1'b0, 1'b0, 1'b0, 8'd4},
    '{4'd1, 4'd1, 8'd2, 16'd8, 1'b1, 1'b1, 1'b1, 1'b0, 8'd3},
    '{4'd0, 4'd2, 8'd5, 16'd3, 1'b0, 1'b1, 1'b1, 1'b1, 8'd3},
    '{4'd3, 4'd1, 8'd7, 16'd8, 1'b0, 1'b1, 1'b0, 1'b0, 8'd8},
    '{4'd0, 4'd1, 8'd0, 16'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1},
    '{4'd1, 4'd2, 8'd1, 16'd0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd1},
    '{4'd5, 4'd4, 8'd2, 16'd3, 1'b0, 1'b1, 1'b0, 1'b0, 8'd3}
  };

  task automatic configure(input vec_t v);
    @(negedge clk);
    waitCfg = v.wt; rdLat = v.lat; compDelay = v.dly; resBit = v.res;
    reloadEn = v.rl; pollLimit = v.lim;
    slvClear = 1'b1;
    @(negedge clk);
    slvClear = 1'b0;
  endtask

  task automatic runSeq(output bit errO, output bit toO, output bit busyOk,
                        output bit pulseOk);
    int n;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busyOk = 1'b1;
    n = 0;
    while (!done && n < 3000) begin
      if (!busy) busyOk = 1'b0;
      @(negedge clk);
      n++;
    end
    if (!busy) busyOk = 1'b0;
    errO = error; toO = timeout;
    @(negedge clk);
    pulseOk = !done && !busy && (n < 3000);
  endtask

  // compare the slave's transfer log with what the requirements predict
  task automatic checkLog(input int idx, input vec_t v);
    bit ok;
    int p;
    bit reloadExp;
    int expLen;
    p = int'(v.expPolls);
    reloadExp = !v.expTo && !v.res && v.rl;
    expLen = 4 + p + (v.expTo ? 0 : 1) + (reloadExp ? 2 : 0);
    ok = (logN >= 4);
    for (int i = 0; i < 4; i++)
      if (ok && (!logW[i] || logA[i] != 12'h200 + 12'(i) ||
                 logD[i] != ((i == 3) ? 32'h81 : 32'h0))) ok = 1'b0;
    check(ok, "R1", $sformatf("vec%0d write chain", idx), logN >= 4 ? logD[3] : 0, 32'h81);
    ok = (logN >= 4 + p);
    for (int i = 4; i < 4 + p; i++)
      if (ok && (logW[i] || logA[i] != 12'h207)) ok = 1'b0;
    check(ok, v.expTo ? "R6" : "R2", $sformatf("vec%0d status polls", idx), logN, expLen);
    ok = (logN == expLen);
    if (ok && !v.expTo) ok = !logW[4 + p] && logA[4 + p] == 12'h204;
    check(ok, v.expTo ? "R6" : "R3", $sformatf("vec%0d result read / length", idx),
          logN, expLen);
    ok = reloadExp ? (reg91 == (REG91_INIT | 32'h1) && logN == expLen &&
                      !logW[5 + p] && logA[5 + p] == 12'h091 &&
                      logW[6 + p] && logA[6 + p] == 12'h091)
                   : (reg91 == REG91_INIT);
    check(ok, "R4", $sformatf("vec%0d reload register", idx), reg91,
          reloadExp ? (REG91_INIT | 32'h1) : REG91_INIT);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit e, t, bOk, pOk;
    vec_t dv;
    int n0;
    rst = 1'b1; start = 1'b0; reloadEn = 1'b0; pollLimit = 16'd8;
    slvClear = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0; slvClear = 1'b0;
    @(negedge clk);
    // R9: reset state
    check(!busy && !done && !error && !timeout && !avRead && !avWrite, "R9",
          "state after reset", {busy, done, error, timeout, avRead, avWrite}, 0);

    for (int i = 0; i < NV; i++) begin
      configure(VECS[i]);
      runSeq(e, t, bOk, pOk);
      check(e == VECS[i].expErr && t == VECS[i].expTo, VECS[i].expTo ? "R6" : "R3",
            $sformatf("vec%0d error/timeout at done", i), {e, t},
            {VECS[i].expErr, VECS[i].expTo});
      check(bOk, "R7", $sformatf("vec%0d busy through sequence", i), bOk, 1);
      check(pOk, "R8", $sformatf("vec%0d single done pulse", i), pOk, 1);
      checkLog(i, VECS[i]);
    end
    check(holdViol == 0, "R5", "stalled request held stable", holdViol, 0);

    // R8: flags held after a failing run, cleared by next start
    dv = VECS[3];
    configure(dv);
    runSeq(e, t, bOk, pOk);
    repeat (5) @(negedge clk);
    check(error && timeout, "R8", "flags held after done", {error, timeout}, 2'b11);
    dv = VECS[0];
    configure(dv);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!error && !timeout, "R8", "flags cleared by start", {error, timeout}, 0);
    while (!done) @(negedge clk);
    @(negedge clk);

    // R7: start while busy is ignored
    dv = VECS[1];
    configure(dv);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    n0 = logN;
    repeat (30) @(negedge clk);
    check(!busy && logN == n0, "R7", "start during busy started nothing", logN, n0);
    checkLog(100, dv);

    // R9: reset in the middle of a stalled transfer
    dv = VECS[7];
    dv.wt = 4'd15;
    configure(dv);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(avWrite && avWaitRequest, "R5", "write held while stalled", avWrite, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!avRead && !avWrite && !busy && !done && !error && !timeout, "R9",
          "mid-sequence reset", {avRead, avWrite, busy}, 0);
    dv = VECS[0];
    configure(dv);
    runSeq(e, t, bOk, pOk);
    check(!e && !t && pOk, "R9", "clean run after reset", {e, t}, 0);
    checkLog(101, dv);

    // R10 is covered by assertions; one bench-side view of it
    check(!(avRead && avWrite), "R10", "no overlapping request at rest", {avRead, avWrite}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule